// File: doc/BRIEF.md
# CAN Interrupt Pending and Priority Encoder

This block gathers interrupt events for a CAN controller: one error event and fifteen message-buffer events. Each event sets a sticky pending flag. Software removes flags by writing ones to a write-one-to-clear register. A separate code-enable mask selects which pending flags may be reported.

From the enabled pending flags the block derives two things. The first is a request bit. The second is a 4-bit source code that names the highest-priority source. The code map is fixed. The error source and the "nothing pending" case both use code 0000, and only the request bit tells them apart.

A status word combines the request bit, the source code and a 3-bit CAN node state supplied by the surrounding controller. The block has a small register bus for software. Reads return data in the cycle after the read strobe.

Top module: `can_irq_ctrl`

Register addresses on `bus_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | Pending flags | Read-only |
| 1 | Clear | Write-only |
| 2 | Code enable | Read/write |
| 3 | Status | Read-only |

## Requirements
- R1: A pulse on `err_evt` sets the error pending flag, and a pulse on `buf_evt[n]` sets the pending flag of buffer n. The pending register at address 0 shows the error flag in bit 15 and the flag of buffer n in bit n. Flags stay set until they are cleared.
- R2: A write to address 1 clears the error flag when data bit 15 is 1, and clears the flag of buffer n when data bit n is 1. A flag whose data bit is 0 is unchanged.
- R3: If an event and a clear write hit the same flag in the same cycle, the flag remains set.
- R4: The code-enable register at address 2 resets to 0 and reads back the last value written. Bit 15 enables the error source and bit n enables buffer n.
- R5: A pending flag whose enable bit is 0 has no effect on the request bit or the source code.
- R6: When no enabled source is pending, the request bit is 0 and the source code is 0000.
- R7: An enabled, pending error source gives request bit 1 and source code 0000. It takes priority over every buffer.
- R8: An enabled, pending buffer n gives request bit 1 and source code n+1. When several buffers qualify, the lowest-numbered one wins.
- R9: The status register at address 3 carries the node state from `node_state` in bits 10:8. The encodings are: 000 not active, 010 error active, 011 error warning, 10x error passive, 11x bus off.
- R10: Output `irq` equals the request bit in every cycle.
- R11: In the status register, the source code sits in bits 3:0 and the request bit sits in bit 4. All other bits read as 0. Writes to addresses 0 and 3 have no effect, and address 1 reads as 0.
- R12: `bus_rdata` takes the value selected by `bus_addr` at the clock edge where `bus_rd` is 1. It holds that value otherwise, and it resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| err_evt | input | 1 | Error event pulse |
| buf_evt | input | 15 | Message buffer event pulses |
| node_state | input | 3 | CAN node state |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can coincide on the same flag in the same cycle: setting a flag through an event, and clearing it through a write. The bench provokes this both in a directed case and at random, by pulsing events during clear writes whose masks overlap them. It then judges the result by reading the pending register and checking that every flag hit by an event survived, while flags that were cleared without an event are gone. The bench also has mask writes land while flags are pending, and compares the resulting code against a model priority function.

// File: rtl/can_irq_pkg.sv
// Package: shared constants and register address map of the CAN interrupt block.
// Assumes a 16-bit register bus with two address bits.
package can_irq_pkg;
    localparam int NBUF   = 15;
    localparam int NSRC   = NBUF + 1;
    localparam int DW     = 16;
    localparam int AW     = 2;
    localparam int NS_W   = 3;

    typedef enum logic [AW-1:0] {
        A_PEND = 2'd0,
        A_CLR  = 2'd1,
        A_EN   = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/can_irq_pend.sv
// Module: array of sticky pending flags, one per interrupt source.
// Assumes set and clear are single-cycle masks; a set beats a clear.
module can_irq_pend #(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        // Hold one flag: set on event, clear on write-one, else keep.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[i] <= 1'b0;
            else if (set_i[i])
                pend_o[i] <= 1'b1;
            else if (clr_i[i])
                pend_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/can_irq_prio.sv
// Module: fixed-priority encoder over enabled pending flags.
// Assumes the top bit is the error source (highest, code 0) and bit n
// a buffer reported as code n+1, the lowest index winning among buffers.
module can_irq_prio #(
    parameter  int NSRC = 16,
    localparam int CW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] en_i,
    output logic            req_o,
    output logic [CW-1:0]   code_o
);
    logic [NSRC-1:0] act;

    // Select the winning source and form request bit and code.
    always_comb begin
        act    = pend_i & en_i;
        req_o  = |act;
        code_o = '0;
        for (int i = NSRC - 2; i >= 0; i--) begin
            if (act[i]) code_o = CW'(i + 1);
        end
        if (act[NSRC-1]) code_o = '0;
    end
endmodule

// File: rtl/can_irq_ctrl.sv
// Module: top of the CAN interrupt pending/priority block.
// Holds pending flags and code-enable mask, decodes the register bus,
// and drives the interrupt output. Read data is registered.
module can_irq_ctrl
    import can_irq_pkg::*;
#(
    parameter  int NB   = NBUF,
    localparam int NS   = NB + 1,
    localparam int CW   = $clog2(NS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            err_evt,
    input  logic [NB-1:0]   buf_evt,
    input  logic [NS_W-1:0] node_state,
    output logic            irq
);
    logic [NS-1:0] evt_vec;
    logic [NS-1:0] clr_mask;
    logic [NS-1:0] pend_q;
    logic [NS-1:0] en_q;
    logic          irq_req;
    logic [CW-1:0] irq_code;
    logic [DW-1:0] rd_mux;

    assign evt_vec = {err_evt, buf_evt};

    // Decode a write to the clear register into a clear mask.
    always_comb begin
        clr_mask = '0;
        if (bus_wr && bus_addr == A_CLR) clr_mask = bus_wdata[NS-1:0];
    end

    can_irq_pend #(.NSRC(NS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_vec),
        .clr_i  (clr_mask),
        .pend_o (pend_q)
    );

    can_irq_prio #(.NSRC(NS)) u_prio (
        .pend_i (pend_q),
        .en_i   (en_q),
        .req_o  (irq_req),
        .code_o (irq_code)
    );

    // Store the code-enable mask on writes to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (bus_wr && bus_addr == A_EN)
            en_q <= bus_wdata[NS-1:0];
    end

    // Select read data; reserved and write-only locations give zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_PEND: rd_mux[NS-1:0] = pend_q;
            A_EN:   rd_mux[NS-1:0] = en_q;
            A_STAT: begin
                rd_mux[CW-1:0]     = irq_code;
                rd_mux[4]          = irq_req;
                rd_mux[10:8]       = node_state;
            end
            default: rd_mux = '0;
        endcase
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign irq = irq_req;
endmodule

// File: rtl/can_irq_ctrl_chk.sv
// Module: assertion checker bound to can_irq_ctrl.
// Assumes the flag order {error, buffers 14..0} and the status layout.
module can_irq_ctrl_chk #(
    parameter int NS = 16,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic [1:0]    bus_addr,
    input logic [15:0]   bus_rdata,
    input logic [2:0]    node_state,
    input logic          irq,
    input logic [NS-1:0] evt_vec,
    input logic [NS-1:0] clr_mask,
    input logic [NS-1:0] pend_q,
    input logic [NS-1:0] en_q,
    input logic          irq_req,
    input logic [CW-1:0] irq_code
);
    // R1: every event leaves its flag set.
    p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(evt_vec)) == $past(evt_vec)));

    // R2: flags cleared without a concurrent event drop; untouched flags hold.
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(clr_mask & ~evt_vec)) == '0));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(evt_vec | clr_mask)) ==
                  ($past(pend_q) & ~$past(evt_vec | clr_mask))));

    // R3: a clear on the same flag as an event leaves it pending.
    p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_vec & clr_mask) != '0) |=> ((pend_q & $past(evt_vec & clr_mask)) != '0));

    // R5 / R6: no enabled pending source means no request and code zero.
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & en_q) == '0) |-> (!irq_req && irq_code == '0));

    // R5 / R8: a reported buffer code names an enabled pending buffer.
    p_code_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_code != '0) |-> (pend_q[irq_code-1] && en_q[irq_code-1]));

    // R7: an enabled pending error yields code zero.
    p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[NS-1] && en_q[NS-1]) |-> (irq_req && irq_code == '0));

    // R10: interrupt output follows the request bit.
    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == irq_req);

    // R11: status reads have zero reserved bits; R9: node state captured.
    p_stat_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |=>
            (bus_rdata[15:11] == '0 && bus_rdata[7:5] == '0));
    p_stat_ns_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |=> (bus_rdata[10:8] == $past(node_state)));

    // R12: read data holds when no read is strobed.
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind can_irq_ctrl can_irq_ctrl_chk #(.NS(NS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .node_state (node_state),
    .irq        (irq),
    .evt_vec    (evt_vec),
    .clr_mask   (clr_mask),
    .pend_q     (pend_q),
    .en_q       (en_q),
    .irq_req    (irq_req),
    .irq_code   (irq_code)
);

// File: tb/can_irq_ctrl_test.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a bench-side model of flags, mask and priority.
module can_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        err_evt = 1'b0;
    logic [14:0] buf_evt = '0;
    logic [2:0]  node_state = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] mpend = '0;
    logic [15:0] men = '0;

    always #2 clk = ~clk;

    can_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_evt(err_evt), .buf_evt(buf_evt), .node_state(node_state), .irq(irq)
    );

    function automatic logic f_req(logic [15:0] p, logic [15:0] e);
        return |(p & e);
    endfunction

    function automatic logic [3:0] f_code(logic [15:0] p, logic [15:0] e);
        logic [15:0] a = p & e;
        if (a[15]) return 4'd0;
        for (int i = 0; i < 15; i++) if (a[i]) return 4'(i + 1);
        return 4'd0;
    endfunction

    function automatic logic [15:0] f_read(logic [1:0] ad, logic [15:0] p,
                                           logic [15:0] e, logic [2:0] ns);
        case (ad)
            2'd0: return p;
            2'd2: return e;
            2'd3: return {5'b0, ns, 3'b0, f_req(p, e), f_code(p, e)};
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // One bus/event cycle; model updated at the edge, outputs checked after it.
    task automatic step(string rq, bit rd, bit wr, logic [1:0] ad, logic [15:0] wd,
                        bit err, logic [14:0] bufs);
        logic [15:0] exp_rd;
        logic [15:0] ev;
        logic [15:0] clr;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = ad; bus_wdata = wd;
        err_evt = err; buf_evt = bufs;
        exp_rd = f_read(ad, mpend, men, node_state);
        ev = {err, bufs};
        clr = (wr && ad == 2'd1) ? wd : 16'h0;
        @(posedge clk);
        mpend = ev | (mpend & ~clr);
        if (wr && ad == 2'd2) men = wd;
        #1;
        if (rd) chk(rq, bus_rdata, exp_rd);
        chk("R10", {15'b0, irq}, {15'b0, f_req(mpend, men)});
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; err_evt = 0; buf_evt = '0;
    endtask

    task automatic rd_chk(string rq, logic [1:0] ad);
        step(rq, 1, 0, ad, 16'h0, 0, '0);
    endtask

    task automatic wr_reg(logic [1:0] ad, logic [15:0] wd);
        step("R12", 0, 1, ad, wd, 0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        node_state = 3'b010;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R12 reset rdata", bus_rdata, 16'h0);
        chk("R10 reset irq", {15'b0, irq}, 16'h0);
        rd_chk("R4 enable reset", 2'd2);
        rd_chk("R9 R6 status idle", 2'd3);

        // R1: events set flags; R5: masked flags report nothing.
        step("R1", 0, 0, 2'd0, 16'h0, 1, 15'h0005);
        rd_chk("R1 pending", 2'd0);
        rd_chk("R5 masked status", 2'd3);
        // R4: enable readback; R7: error wins.
        wr_reg(2'd2, 16'hFFFF);
        rd_chk("R4 enable readback", 2'd2);
        rd_chk("R7 error code", 2'd3);
        // R2: clear error only, zero bits leave buffers.
        wr_reg(2'd1, 16'h8000);
        rd_chk("R2 pending after clear", 2'd0);
        rd_chk("R8 buffer0 code", 2'd3);
        wr_reg(2'd2, 16'h7FFE);
        rd_chk("R5 R8 buffer2 code", 2'd3);
        // R8: buffer 14 alone gives code 15.
        wr_reg(2'd1, 16'hFFFF);
        step("R8", 0, 0, 2'd0, 16'h0, 0, 15'h4000);
        rd_chk("R8 buffer14 code", 2'd3);
        // R3: event and clear on same flag together.
        step("R3", 0, 1, 2'd1, 16'hFFFF, 1, 15'h0010);
        rd_chk("R3 event beats clear", 2'd0);
        // R11: writes to pending/status ignored, clear reads 0.
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd3, 16'hFFFF);
        rd_chk("R11 pending unchanged", 2'd0);
        rd_chk("R11 status layout", 2'd3);
        rd_chk("R11 clear reads zero", 2'd1);
        // R9: every node state encoding.
        for (int s = 0; s < 8; s++) begin
            node_state = 3'(s);
            rd_chk("R9 node state", 2'd3);
        end

        // Random traffic with overlapping events and clears.
        for (int k = 0; k < 400; k++) begin
            int op = int'($urandom % 4);
            bit er = ($urandom % 6) == 0;
            logic [14:0] bf = 15'($urandom & $urandom & $urandom);
            node_state = 3'($urandom);
            case (op)
                0: step("R12 R1 random read", 1, 0, 2'($urandom), 16'h0, er, bf);
                1: step("R2 R3 random clear", 0, 1, 2'd1, 16'($urandom), er, bf);
                2: step("R4 random enable", 0, 1, 2'd2, 16'($urandom), er, bf);
                default: step("R8 random status", 1, 0, 2'd3, 16'h0, er, bf);
            endcase
        end
        rd_chk("R1 final pending", 2'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule